// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block drives the bus activity a processor core performs when it switches into exception processing. The core supplies a one-cycle start strobe together with the kind of exception (software trap, external interrupt or reset), the address mode (16-bit or extended), the vector table address, the current stack pointer, the program counter to save and the flag byte. The block then walks a fixed ordered list of bus states. For each state it presents a cycle type and an address, and for writes a data word. It waits on bus-ready for each bus cycle.

Trap and interrupt entries first read one instruction word at the supplied PC. The next instruction (trap) and the interrupted instruction (interrupt) are both given through that PC input. Then come internal idle states, then two stack writes that hold a two-word frame, then the vector read or reads. Reset entries skip the stacking and start at the vector read. Every entry ends with a second run of internal idle states and a read of the first handler word. The handler address is built from the captured vector word or words and stays visible afterwards.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle: after that edge `cyc` is 2'b00 (no cycle), `busy` is 0 and `done` is 0. This holds even when a sequence was running.
- R2: For `kind` 2'b00 (trap) and 2'b01 (interrupt) the order is: a word read (`cyc`=2'b01) at `pc`, then GAP_CYCLES (default 2) internal states (`cyc`=2'b11), then two word writes (`cyc`=2'b10), then the vector read(s).
- R3: The first stack write goes to `sp`-2 with data `pc[15:0]`. The second goes to `sp`-4 with data {`flags`, `pc[23:16]`}. Both use modulo-2^24 arithmetic.
- R4: In extended mode (`ext_mode`=1) a read at `vec_addr` is followed at once by a read at `vec_addr`+2. In 16-bit mode (`ext_mode`=0) only the read at `vec_addr` occurs.
- R5: After the last vector read there are GAP_CYCLES internal states and then a word read at the handler address. In extended mode the handler address is {first word[7:0], second word}. In 16-bit mode it is {8'h00, first word}. `handler` holds this value after the sequence ends.
- R6: For `kind` 2'b10 or 2'b11 (reset) there is no instruction read, no internal gap before the vectors and no write. The first state is the read at `vec_addr`.
- R7: A read or write state keeps its type, address and data while `bus_rdy` is low and completes on the first edge with `bus_rdy` high. Internal states advance every clock whatever `bus_rdy` is.
- R8: `done` is high only in the cycle where the handler read completes (`bus_rdy` high). The block is idle (`busy`=0, `cyc`=2'b00) in the next cycle.
- R9: A start strobe while `busy` is 1 is ignored. The running sequence continues unchanged, and no new sequence begins after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an exception entry, taken only when idle |
| kind | input | 2 | 00 trap, 01 interrupt, 1x reset |
| ext_mode | input | 1 | 1 selects extended addressing (two vector words) |
| vec_addr | input | 24 | Address of the vector entry |
| pc | input | 24 | Program counter to save and to read first |
| flags | input | 8 | Flag byte placed in the upper stacked word |
| sp | input | 24 | Stack pointer before the exception |
| bus_rdy | input | 1 | High when the current bus cycle completes this edge |
| rdata | input | 16 | Read data returned by the bus |
| cyc | output | 2 | 00 none, 01 word read, 10 word write, 11 internal |
| addr | output | 24 | Bus address of the current state |
| wdata | output | 16 | Write data during write states |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Handler read completes this cycle |
| handler | output | 24 | Handler address built from the vector words |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives in the middle of a running sequence while the bus is also stalling. The stimulus table pulses start, with the reset kind and the other mode, at the fourth state of some entries. The bench then compares every later state against the expected list, so the ignored request is seen. The same table gives each entry a stall count that holds bus_rdy low before every bus cycle, including the final handler read. The bench also drives bus_rdy low during internal states, which shows that the idle gaps advance on their own.

// File: rtl/exc_seq_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes a single clock domain; encodings here are visible at the top ports.
package exc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREF,
        ST_GAP1,
        ST_PUSHL,
        ST_PUSHH,
        ST_VEC0,
        ST_VEC1,
        ST_GAP2,
        ST_FETCH
    } step_e;

    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_RD   = 2'b01,
        CYC_WR   = 2'b10,
        CYC_INT  = 2'b11
    } cyc_e;

    // Maps a sequence step to the cycle type it presents on the bus.
    function automatic cyc_e cyc_of(step_e s);
        case (s)
            ST_PREF, ST_VEC0, ST_VEC1, ST_FETCH: return CYC_RD;
            ST_PUSHL, ST_PUSHH:                  return CYC_WR;
            ST_GAP1, ST_GAP2:                    return CYC_INT;
            default:                             return CYC_NONE;
        endcase
    endfunction

    // True for steps that wait on bus-ready.
    function automatic logic is_bus_step(step_e s);
        return (cyc_of(s) == CYC_RD) || (cyc_of(s) == CYC_WR);
    endfunction

endpackage

// File: rtl/exc_seq_fsm.sv
// Step controller: walks the ordered exception entry steps.
// Assumes start is sampled only in idle; kind and mode are latched at accept
// and held until the sequence returns to idle.
module exc_seq_fsm
    import exc_seq_pkg::*;
#(
    parameter int GAP_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] kind,
    input  logic       ext_mode,
    input  logic       bus_rdy,
    output step_e      step_o,
    output logic       accept_o,
    output logic       ext_o
);

    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    step_e            step_q, step_nxt;
    logic             is_reset_q;
    logic             ext_q;
    logic [CNT_W-1:0] gap_cnt_q;
    logic             gap_end;

    assign accept_o = (step_q == ST_IDLE) && start;
    assign gap_end  = (gap_cnt_q == GAP_LAST);
    assign step_o   = step_q;
    assign ext_o    = ext_q;

    // Next-step selection from the current step, bus-ready and gap count.
    always_comb begin
        step_nxt = step_q;
        case (step_q)
            ST_IDLE:  if (start)   step_nxt = kind[1] ? ST_VEC0 : ST_PREF;
            ST_PREF:  if (bus_rdy) step_nxt = ST_GAP1;
            ST_GAP1:  if (gap_end) step_nxt = ST_PUSHL;
            ST_PUSHL: if (bus_rdy) step_nxt = ST_PUSHH;
            ST_PUSHH: if (bus_rdy) step_nxt = ST_VEC0;
            ST_VEC0:  if (bus_rdy) step_nxt = ext_q ? ST_VEC1 : ST_GAP2;
            ST_VEC1:  if (bus_rdy) step_nxt = ST_GAP2;
            ST_GAP2:  if (gap_end) step_nxt = ST_FETCH;
            ST_FETCH: if (bus_rdy) step_nxt = ST_IDLE;
            default:               step_nxt = ST_IDLE;
        endcase
    end

    // Step register and the exception context latched at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= ST_IDLE;
            is_reset_q <= 1'b0;
            ext_q      <= 1'b0;
        end else begin
            step_q <= step_nxt;
            if (accept_o) begin
                is_reset_q <= kind[1];
                ext_q      <= ext_mode;
            end
        end
    end

    // Counts internal idle states inside either gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt_q <= '0;
        end else if ((step_q == ST_GAP1) || (step_q == ST_GAP2)) begin
            gap_cnt_q <= gap_end ? '0 : gap_cnt_q + 1'b1;
        end else begin
            gap_cnt_q <= '0;
        end
    end

    // R7
    bus_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bus_step(step_q) && !bus_rdy) |=> $stable(step_q));

    // R7
    gap_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_GAP1 && gap_end) |=> (step_q == ST_PUSHL));

    // R9
    ctx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_IDLE) |=> ($stable(is_reset_q) && $stable(ext_q)));

    // R6
    reset_no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reset_q && step_q != ST_IDLE) |->
            !(step_q inside {ST_PREF, ST_GAP1, ST_PUSHL, ST_PUSHH}));

endmodule

// File: rtl/exc_vec_capture.sv
// Vector capture: stores the vector word(s) as their reads complete and
// forms the handler start address. Assumes ADDR_W lies between WORD_W+1
// and 2*WORD_W; the upper address bits come from the first word's low bits.
module exc_vec_capture
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              bus_rdy,
    input  logic              ext,
    input  logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] handler_o
);

    localparam int HI_W = ADDR_W - WORD_W;

    logic [WORD_W-1:0] vec_w0_q;
    logic [WORD_W-1:0] vec_w1_q;

    // Latches each vector word on the edge its read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_w0_q <= '0;
            vec_w1_q <= '0;
        end else if (bus_rdy) begin
            if (step == ST_VEC0) vec_w0_q <= rdata;
            if (step == ST_VEC1) vec_w1_q <= rdata;
        end
    end

    // Joins the captured words according to the latched address mode.
    always_comb begin
        if (ext) handler_o = {vec_w0_q[HI_W-1:0], vec_w1_q};
        else     handler_o = {{HI_W{1'b0}}, vec_w0_q};
    end

    // R4
    vec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_VEC1) |-> ext);

    // R5
    fetch_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FETCH) |-> ($past(step) inside {ST_GAP2, ST_FETCH}));

endmodule

// File: rtl/exc_frame_regs.sv
// Frame and address unit: holds the saved PC, flags, stack pointer and vector
// address from accept, and drives the bus address and write data per step.
// Assumes FLAG_W + (ADDR_W - WORD_W) equals WORD_W for the upper stacked word.
module exc_frame_regs
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  step_e             step,
    input  logic [ADDR_W-1:0] pc,
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] vec_addr,
    input  logic [ADDR_W-1:0] handler,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);

    localparam logic [ADDR_W-1:0] WORD_BYTES  = ADDR_W'(WORD_W / 8);
    localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(2 * (WORD_W / 8));

    logic [ADDR_W-1:0] pc_q;
    logic [FLAG_W-1:0] flags_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] frame_base;

    // Latches the exception context when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
            sp_q    <= '0;
            vec_q   <= '0;
        end else if (accept) begin
            pc_q    <= pc;
            flags_q <= flags;
            sp_q    <= sp;
            vec_q   <= vec_addr;
        end
    end

    assign frame_base = sp_q - FRAME_BYTES;

    // Selects the bus address and write data for the current step.
    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        case (step)
            ST_PREF:  addr_o = pc_q;
            ST_PUSHL: begin
                addr_o  = frame_base + WORD_BYTES;
                wdata_o = pc_q[WORD_W-1:0];
            end
            ST_PUSHH: begin
                addr_o  = frame_base;
                wdata_o = {flags_q, pc_q[ADDR_W-1:WORD_W]};
            end
            ST_VEC0:  addr_o = vec_q;
            ST_VEC1:  addr_o = vec_q + WORD_BYTES;
            ST_FETCH: addr_o = handler;
            default:  addr_o = '0;
        endcase
    end

    // R3
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_PUSHH && $past(step) == ST_PUSHL) |->
            (addr_o + WORD_BYTES == $past(addr_o)));

    // R4
    vec_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_VEC1 && $past(step) == ST_VEC0) |->
            (addr_o == $past(addr_o) + WORD_BYTES));

endmodule

// File: rtl/exc_entry_seq.sv
// Top of the exception entry bus sequencer. Ties the step controller, the
// frame/address unit and the vector capture together and drives the bus
// outputs. Assumes the bus completes a read or write on an edge with bus_rdy.
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int WORD_W     = 16,
    parameter int FLAG_W     = 8,
    parameter int GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        kind,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] vec_addr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] sp,
    input  logic              bus_rdy,
    input  logic [WORD_W-1:0] rdata,
    output logic [1:0]        cyc,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] handler
);

    step_e step;
    logic  accept;
    logic  ext;

    exc_seq_fsm #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (kind),
        .ext_mode (ext_mode),
        .bus_rdy  (bus_rdy),
        .step_o   (step),
        .accept_o (accept),
        .ext_o    (ext)
    );

    exc_vec_capture #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .bus_rdy   (bus_rdy),
        .ext       (ext),
        .rdata     (rdata),
        .handler_o (handler)
    );

    exc_frame_regs #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .FLAG_W (FLAG_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .step     (step),
        .pc       (pc),
        .flags    (flags),
        .sp       (sp),
        .vec_addr (vec_addr),
        .handler  (handler),
        .addr_o   (addr),
        .wdata_o  (wdata)
    );

    // Bus-facing status derived from the current step.
    always_comb begin
        cyc  = cyc_of(step);
        busy = (step != ST_IDLE);
        done = (step == ST_FETCH) && bus_rdy;
    end

    // R8
    done_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == CYC_RD && addr == handler));

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && cyc == CYC_NONE));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cyc == CYC_NONE && !done));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    localparam logic [1:0] C_NONE = 2'b00;
    localparam logic [1:0] C_RD   = 2'b01;
    localparam logic [1:0] C_WR   = 2'b10;
    localparam logic [1:0] C_INT  = 2'b11;
    localparam int GAPS  = 2;
    localparam int LIMIT = 20000;

    typedef struct packed {
        logic [1:0]  kind;
        logic        ext;
        logic [23:0] vec;
        logic [23:0] pc;
        logic [7:0]  flags;
        logic [23:0] sp;
        logic [15:0] v0;
        logic [15:0] v1;
        logic [3:0]  stall;
        logic        poke;
    } case_t;

    localparam int NCASE = 6;
    localparam case_t CASES [NCASE] = '{
        '{2'b00, 1'b0, 24'h000010, 24'h001234, 8'h85, 24'h00FF00, 16'h4000, 16'h0000, 4'd0, 1'b0},
        '{2'b00, 1'b1, 24'h000020, 24'h3A5678, 8'h40, 24'h7FFE10, 16'hAB12, 16'h3456, 4'd2, 1'b0},
        '{2'b01, 1'b0, 24'h00001C, 24'h0009AE, 8'h0F, 24'h000800, 16'h2222, 16'hFFFF, 4'd1, 1'b1},
        '{2'b01, 1'b1, 24'h000040, 24'hFF0002, 8'hC3, 24'h000004, 16'h00FF, 16'hFFFE, 4'd3, 1'b0},
        '{2'b10, 1'b0, 24'h000000, 24'h00AAAA, 8'h11, 24'h001000, 16'h0100, 16'h7777, 4'd1, 1'b0},
        '{2'b11, 1'b1, 24'h000000, 24'h005555, 8'h22, 24'h002000, 16'h5A01, 16'h8000, 4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic        ext_mode = 1'b0;
    logic [23:0] vec_addr = '0;
    logic [23:0] pc = '0;
    logic [7:0]  flags = '0;
    logic [23:0] sp = '0;
    logic        bus_rdy = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  cyc;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic        busy;
    logic        done;
    logic [23:0] handler;

    case_t cur = '0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit timeout = 1'b0;

    logic [1:0]  exp_cyc  [16];
    logic [23:0] exp_addr [16];
    logic [15:0] exp_wd   [16];
    int          exp_n;
    logic [23:0] exp_hdl;

    exc_entry_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (kind),
        .ext_mode (ext_mode),
        .vec_addr (vec_addr),
        .pc       (pc),
        .flags    (flags),
        .sp       (sp),
        .bus_rdy  (bus_rdy),
        .rdata    (rdata),
        .cyc      (cyc),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (busy),
        .done     (done),
        .handler  (handler)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) timeout <= 1'b1;
    end

    // Simple memory: the vector entry words, anything else a fixed pattern.
    always_comb begin
        if (addr == cur.vec)               rdata = cur.v0;
        else if (addr == cur.vec + 24'd2)  rdata = cur.v1;
        else                               rdata = 16'hC3C3;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add_exp(input logic [1:0] c, input logic [23:0] a, input logic [15:0] d);
        exp_cyc[exp_n]  = c;
        exp_addr[exp_n] = a;
        exp_wd[exp_n]   = d;
        exp_n++;
    endtask

    task automatic build_exp(input case_t c);
        exp_n = 0;
        exp_hdl = c.ext ? {c.v0[7:0], c.v1} : {8'h00, c.v0};
        if (!c.kind[1]) begin
            add_exp(C_RD, c.pc, 16'h0);
            for (int g = 0; g < GAPS; g++) add_exp(C_INT, 24'h0, 16'h0);
            add_exp(C_WR, c.sp - 24'd2, c.pc[15:0]);
            add_exp(C_WR, c.sp - 24'd4, {c.flags, c.pc[23:16]});
        end
        add_exp(C_RD, c.vec, 16'h0);
        if (c.ext) add_exp(C_RD, c.vec + 24'd2, 16'h0);
        for (int g = 0; g < GAPS; g++) add_exp(C_INT, 24'h0, 16'h0);
        add_exp(C_RD, exp_hdl, 16'h0);
    endtask

    task automatic run_case(input case_t c);
        int idx;
        int stall_cnt;
        bit held;
        bit complete;
        logic [1:0]  h_cyc;
        logic [23:0] h_addr;
        logic [15:0] h_wd;
        cur = c;
        build_exp(c);
        @(negedge clk);
        kind = c.kind; ext_mode = c.ext; vec_addr = c.vec;
        pc = c.pc; flags = c.flags; sp = c.sp; start = 1'b1;
        @(negedge clk);
        idx = 0; stall_cnt = 0; held = 1'b0;
        h_cyc = '0; h_addr = '0; h_wd = '0;
        while (idx < exp_n && !timeout) begin
            start = 1'b0;
            if (c.poke && idx == 3 && !held) begin
                start = 1'b1; kind = 2'b10; ext_mode = ~c.ext;
                vec_addr = 24'h00ABC0;
            end
            if (cyc == C_RD || cyc == C_WR) bus_rdy = (stall_cnt >= int'(c.stall));
            else bus_rdy = 1'b0;
            #1;
            if (held) begin
                // R7: a stalled bus state keeps type, address and data
                chk(cyc == h_cyc && addr == h_addr && wdata == h_wd, "R7 stall hold",
                    {6'h0, cyc, addr}, {6'h0, h_cyc, h_addr});
            end
            complete = (cyc == C_INT) || bus_rdy;
            // R8: done only when the handler read completes
            chk(done == (complete && idx == exp_n - 1), "R8 done timing",
                {31'h0, done}, {31'h0, complete && idx == exp_n - 1});
            if (complete) begin
                // R2 R6: cycle type order
                chk(cyc == exp_cyc[idx], c.kind[1] ? "R6 reset order" : "R2 entry order",
                    {30'h0, cyc}, {30'h0, exp_cyc[idx]});
                if (exp_cyc[idx] != C_INT) begin
                    // R4 R5: addresses of reads, including vectors and handler fetch
                    chk(addr == exp_addr[idx], (idx == exp_n - 1) ? "R5 handler fetch" : "R4 address",
                        {8'h0, addr}, {8'h0, exp_addr[idx]});
                end
                if (exp_cyc[idx] == C_WR) begin
                    // R3: stack frame data
                    chk(wdata == exp_wd[idx], "R3 frame data", {16'h0, wdata}, {16'h0, exp_wd[idx]});
                end
                idx++; stall_cnt = 0; held = 1'b0;
            end else begin
                held = 1'b1; stall_cnt++;
                h_cyc = cyc; h_addr = addr; h_wd = wdata;
            end
            @(negedge clk);
        end
        start = 1'b0;
        bus_rdy = 1'b0;
        #1;
        // R8 R9: idle after done, no restarted sequence from a mid-run start
        chk(!busy && cyc == C_NONE, c.poke ? "R9 start ignored" : "R8 idle after done",
            {31'h0, busy}, 32'h0);
        // R5: handler address kept
        chk(handler == exp_hdl, "R5 handler value", {8'h0, handler}, {8'h0, exp_hdl});
        @(negedge clk);
        #1;
        chk(!busy && handler == exp_hdl, "R9 still idle", {8'h0, handler}, {8'h0, exp_hdl});
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(cyc == C_NONE && !busy && !done, "R1 reset state", {29'h0, cyc, busy}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NCASE; i++) begin
            if (!timeout) run_case(CASES[i]);
        end

        // R1: reset in the middle of a running sequence
        cur = CASES[0];
        @(negedge clk);
        kind = 2'b00; ext_mode = 1'b0; pc = 24'h000100; sp = 24'h000200;
        vec_addr = 24'h000010; start = 1'b1; bus_rdy = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(busy, "R1 running before reset", {31'h0, busy}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(cyc == C_NONE && !busy && !done, "R1 reset mid-sequence", {29'h0, cyc, busy}, 32'h0);
        rst_n = 1'b1;
        bus_rdy = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!busy, "R1 stays idle", {31'h0, busy}, 32'h0);

        if (timeout) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule